// File: doc/BRIEF.md
# Timer-Paced DAC Sample Controller

This block feeds a pair of DAC channels from a small sample queue at a steady, programmable rate. A free-running interval timer counts cycles of the divided controller clock. Each time the timer wraps it fires a one-cycle trigger, and the trigger takes the oldest sample from the queue and places it on the channel outputs. The output sample rate is therefore the controller clock divided by the programmed interval.

Two steering modes are offered. In simultaneous mode every sample drives both channels together. In alternate mode successive samples are dealt to channel 0 and channel 1 in turn, starting with channel 0 after any reset. A digital-path enable decides whether the channel outputs come from this controller or from two direct-write inputs. A flush pulse empties the queue while leaving the configuration alone. A controller reset pulse restarts the timer and the steering. A trigger that finds the queue empty leaves the outputs unchanged and raises a sticky underflow flag.

Top module: `dac_pacer`

## Requirements
- R1: After the asynchronous reset `rstN` is released, with `digEnable` high, both channel outputs read 0, `underflow` is 0 and `fifoFull` is 0.
- R2: While `trigEnable` and `digEnable` are both high, the timer counts from 0 up to `interval`-1 and a trigger takes effect at the clock edge that ends the `interval`-th enabled cycle, then every `interval` cycles after that; an `interval` of 0 behaves as 1.
- R3: While `trigEnable` is low no trigger happens: the timer is held at 0, the queue keeps its samples and the outputs keep their values.
- R4: With `altMode` = 0 (simultaneous), each trigger moves one sample from the queue onto both channel outputs.
- R5: With `altMode` = 1 (alternate), the first sample after reset or controller reset goes to channel 0, the next to channel 1, and so on in turn; the channel not chosen keeps its value.
- R6: A high `fifoFlush` cycle empties the queue; a write in that cycle is dropped and a trigger in that cycle sees an empty queue; `interval`, `altMode` and the steering position are not changed.
- R7: A trigger with the queue empty leaves both outputs unchanged, does not advance the steering, and sets `underflow`, which stays high until `rstN` or `ctlReset`.
- R8: A high `ctlReset` cycle clears the timer, returns steering to channel 0 and clears `underflow`; queue contents and the channel output values are kept.
- R9: With `digEnable` low, `dacOut0`/`dacOut1` show `directData0`/`directData1` and the timer is held at 0; with `digEnable` high they show the controller's channel values.
- R10: The queue holds `DEPTH` samples in arrival order; `fifoFull` is high when it holds `DEPTH`, and a write while full is dropped.
- R11: A write into an empty queue in the same cycle as a trigger is stored; the trigger counts as an underflow and the written sample is used by the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlReset | input | 1 | Synchronous controller reset pulse (timer, steering, underflow) |
| fifoFlush | input | 1 | Synchronous queue flush pulse |
| digEnable | input | 1 | 1: outputs driven by the controller; 0: by the direct inputs |
| trigEnable | input | 1 | Lets the interval timer run and fire triggers |
| altMode | input | 1 | 1: alternate steering; 0: simultaneous |
| interval | input | IW | Trigger period in clock cycles (0 treated as 1) |
| wrEn | input | 1 | Write strobe for the sample queue |
| wrData | input | DW | Sample written into the queue |
| directData0 | input | DW | Direct value for channel 0 when `digEnable` is low |
| directData1 | input | DW | Direct value for channel 1 when `digEnable` is low |
| dacOut0 | output | DW | Channel 0 code to the converter |
| dacOut1 | output | DW | Channel 1 code to the converter |
| fifoFull | output | 1 | Queue holds DEPTH samples |
| underflow | output | 1 | Sticky: a trigger found the queue empty |

## Verification
A trigger and a queue write can land in the same clock edge while the queue is empty, and a trigger can also coincide with a flush. The bench provokes the first by letting the timer reach its last count and issuing a single write exactly in the wrap cycle, then judges that `underflow` rises, the outputs hold, and the written sample appears only one full interval later. For the second it flushes with a write in the same cycle and then triggers, expecting an underflow and unchanged outputs, with the steering position kept for the next sample.

// File: rtl/dac_pacer_pkg.sv
package dac_pacer_pkg;
  // Per-cycle commands from the control to the datapath.
  typedef struct packed {
    logic pop;          // take the head sample out of the queue
    logic load0;        // copy the head sample to channel 0
    logic load1;        // copy the head sample to channel 1
    logic underflowSet; // trigger found no sample
  } strobe_t;
endpackage

// File: rtl/dac_pacer_ctrl.sv
module dac_pacer_ctrl
  import dac_pacer_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlReset,
  input  logic          fifoFlush,
  input  logic          digEnable,
  input  logic          trigEnable,
  input  logic          altMode,
  input  logic [IW-1:0] interval,
  input  logic          fifoEmpty,
  output strobe_t       stb,
  output logic          underflow
);
  logic [IW-1:0] cnt;
  logic [IW-1:0] lastCnt;
  logic          runEn;
  logic          trig;
  logic          emptyEff;
  logic          nextCh;

  assign lastCnt  = (interval == '0) ? '0 : interval - IW'(1);
  assign runEn    = trigEnable && digEnable;
  assign trig     = runEn && !ctlReset && (cnt >= lastCnt);
  assign emptyEff = fifoEmpty || fifoFlush;

  always_comb begin
    stb.pop          = trig && !emptyEff;
    stb.underflowSet = trig && emptyEff;
    stb.load0        = stb.pop && (!altMode || !nextCh);
    stb.load1        = stb.pop && (!altMode || nextCh);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      nextCh    <= 1'b0;
      underflow <= 1'b0;
    end else if (ctlReset) begin
      cnt       <= '0;
      nextCh    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (!runEn || trig) cnt <= '0;
      else                cnt <= cnt + IW'(1);
      if (stb.pop && altMode) nextCh <= !nextCh;
      if (stb.underflowSet)   underflow <= 1'b1;
    end
  end

  AST_TRIG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop || stb.underflowSet) |-> (trigEnable && digEnable)); // R3

  AST_ALT_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pop && altMode) |=> (nextCh != $past(nextCh))); // R5

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !ctlReset) |=> underflow); // R7

  AST_CTL_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctlReset |=> (!underflow && cnt == '0)); // R8
endmodule

// File: rtl/dac_pacer_data.sv
module dac_pacer_data
  import dac_pacer_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoFlush,
  input  logic          digEnable,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] directData0,
  input  logic [DW-1:0] directData1,
  input  strobe_t       stb,
  output logic [DW-1:0] dacOut0,
  output logic [DW-1:0] dacOut1,
  output logic          fifoEmpty,
  output logic          fifoFull
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic [DW-1:0] outReg0, outReg1;
  logic [DW-1:0] headData;
  logic          wrAcc;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));
  assign wrAcc     = wrEn && !fifoFull && !fifoFlush;
  assign headData  = mem[rdPtr];

  function automatic logic [AW-1:0] ptrNext(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wrAcc) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (fifoFlush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (wrAcc)   wrPtr <= ptrNext(wrPtr);
      if (stb.pop) rdPtr <= ptrNext(rdPtr);
      count <= count + CW'(wrAcc) - CW'(stb.pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg0 <= '0;
      outReg1 <= '0;
    end else begin
      if (stb.load0) outReg0 <= headData;
      if (stb.load1) outReg1 <= headData;
    end
  end

  assign dacOut0 = digEnable ? outReg0 : directData0;
  assign dacOut1 = digEnable ? outReg1 : directData1;

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !fifoEmpty); // R7

  AST_HOLD_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.underflowSet |=> ($stable(outReg0) && $stable(outReg1))); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |=> fifoEmpty); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R10
endmodule

// File: rtl/dac_pacer.sv
module dac_pacer
  import dac_pacer_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlReset,
  input  logic          fifoFlush,
  input  logic          digEnable,
  input  logic          trigEnable,
  input  logic          altMode,
  input  logic [IW-1:0] interval,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] directData0,
  input  logic [DW-1:0] directData1,
  output logic [DW-1:0] dacOut0,
  output logic [DW-1:0] dacOut1,
  output logic          fifoFull,
  output logic          underflow
);
  strobe_t stb;
  logic    fifoEmpty;

  dac_pacer_ctrl #(.IW(IW)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctlReset(ctlReset), .fifoFlush(fifoFlush),
    .digEnable(digEnable), .trigEnable(trigEnable), .altMode(altMode),
    .interval(interval), .fifoEmpty(fifoEmpty), .stb(stb),
    .underflow(underflow)
  );

  dac_pacer_data #(.DW(DW), .DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .fifoFlush(fifoFlush), .digEnable(digEnable),
    .wrEn(wrEn), .wrData(wrData), .directData0(directData0),
    .directData1(directData1), .stb(stb), .dacOut0(dacOut0),
    .dacOut1(dacOut1), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull)
  );
endmodule

// File: tb/dac_pacer_tb_top.sv
`timescale 1ns/1ps
module dac_pacer_tb_top;
  localparam int DW = 8;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ctlReset = 1'b0, fifoFlush = 1'b0, digEnable = 1'b1;
  logic          trigEnable = 1'b0, altMode = 1'b0, wrEn = 1'b0;
  logic [IW-1:0] interval = '0;
  logic [DW-1:0] wrData = '0, directData0 = '0, directData1 = '0;
  logic [DW-1:0] dacOut0, dacOut1;
  logic          fifoFull, underflow;

  int testCnt = 0;
  int failCnt = 0;
  logic [2*DW-1:0] expQ [$];

  always #2.5 clk = ~clk;

  dac_pacer #(.DW(DW), .IW(IW), .DEPTH(4)) dut_i (
    .clk(clk), .rstN(rstN), .ctlReset(ctlReset), .fifoFlush(fifoFlush),
    .digEnable(digEnable), .trigEnable(trigEnable), .altMode(altMode),
    .interval(interval), .wrEn(wrEn), .wrData(wrData),
    .directData0(directData0), .directData1(directData1),
    .dacOut0(dacOut0), .dacOut1(dacOut1), .fifoFull(fifoFull),
    .underflow(underflow)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    wrEn = 1'b1; wrData = d;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic pulseCtl();
    ctlReset = 1'b1; tick(1); ctlReset = 1'b0;
  endtask

  // Driver side of the scoreboard: record the expected channel pair.
  task automatic sbExpect(input logic [DW-1:0] e0, input logic [DW-1:0] e1);
    expQ.push_back({e0, e1});
  endtask

  // Monitor side: pop the oldest expectation and compare with the outputs.
  task automatic sbMonitor(input string req);
    logic [2*DW-1:0] e;
    testCnt++;
    if (expQ.size() == 0) begin
      failCnt++;
      $display("FAIL %s: scoreboard empty, actual %h/%h", req, dacOut0, dacOut1);
    end else begin
      e = expQ.pop_front();
      if ({dacOut0, dacOut1} !== e) begin
        failCnt++;
        $display("FAIL %s: actual %h/%h expected %h/%h", req,
                 dacOut0, dacOut1, e[2*DW-1:DW], e[DW-1:0]);
      end
    end
  endtask

  task automatic checkBit(input string req, input string what,
                          input logic act, input logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    sbExpect(8'h00, 8'h00); sbMonitor("R1");
    checkBit("R1", "underflow", underflow, 1'b0);
    checkBit("R1", "fifoFull", fifoFull, 1'b0);

    // R2 / R4: simultaneous mode, interval 3
    interval = 3; altMode = 1'b0;
    push(8'h11); push(8'h22);
    trigEnable = 1'b1;
    tick(2); sbExpect(8'h00, 8'h00); sbMonitor("R2 no early trigger");
    tick(1); sbExpect(8'h11, 8'h11); sbMonitor("R4 first sample");
    tick(3); sbExpect(8'h22, 8'h22); sbMonitor("R2 period");
    tick(3); sbExpect(8'h22, 8'h22); sbMonitor("R7 hold on empty");
    checkBit("R7", "underflow", underflow, 1'b1);
    trigEnable = 1'b0;

    // R3: disabled timer consumes nothing
    push(8'h33);
    tick(6); sbExpect(8'h22, 8'h22); sbMonitor("R3 disabled");

    // R8: controller reset clears underflow, keeps outputs
    pulseCtl();
    checkBit("R8", "underflow", underflow, 1'b0);
    sbExpect(8'h22, 8'h22); sbMonitor("R8 outputs kept");

    // R5: alternate mode, interval 2; 33 is still queued (R8 keeps queue)
    altMode = 1'b1; interval = 2;
    push(8'h44); push(8'h55);
    trigEnable = 1'b1;
    tick(2); sbExpect(8'h33, 8'h22); sbMonitor("R5 first to ch0");
    tick(2); sbExpect(8'h33, 8'h44); sbMonitor("R5 second to ch1");
    tick(2); sbExpect(8'h55, 8'h44); sbMonitor("R5 third to ch0");
    tick(2); sbExpect(8'h55, 8'h44); sbMonitor("R7 alt underflow");
    trigEnable = 1'b0;

    // R6: flush with a same-cycle write, then trigger
    push(8'h66); push(8'h77);
    fifoFlush = 1'b1; wrEn = 1'b1; wrData = 8'h88;
    tick(1);
    fifoFlush = 1'b0; wrEn = 1'b0;
    pulseCtl();
    checkBit("R6", "fifoFull after flush", fifoFull, 1'b0);
    interval = 1; trigEnable = 1'b1;
    tick(1); sbExpect(8'h55, 8'h44); sbMonitor("R6 flushed queue");
    checkBit("R6", "underflow after flush", underflow, 1'b1);
    trigEnable = 1'b0;
    // steering was reset to ch0 by ctlReset; altMode kept by flush
    push(8'h99);
    trigEnable = 1'b1;
    tick(1); sbExpect(8'h99, 8'h44); sbMonitor("R6 config kept");
    trigEnable = 1'b0;

    // R11: write and trigger in the same cycle on an empty queue
    pulseCtl();
    altMode = 1'b0; interval = 4; trigEnable = 1'b1;
    tick(3);
    push(8'hAA);
    checkBit("R11", "underflow", underflow, 1'b1);
    sbExpect(8'h99, 8'h44); sbMonitor("R11 hold");
    tick(4); sbExpect(8'hAA, 8'hAA); sbMonitor("R11 sample kept");
    trigEnable = 1'b0;

    // R10: fill past depth, drain in order
    pulseCtl();
    push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05);
    checkBit("R10", "fifoFull", fifoFull, 1'b1);
    interval = 0; trigEnable = 1'b1;
    tick(1); sbExpect(8'h01, 8'h01); sbMonitor("R2 interval zero");
    tick(1); sbExpect(8'h02, 8'h02); sbMonitor("R10 order");
    tick(1); sbExpect(8'h03, 8'h03); sbMonitor("R10 order");
    tick(1); sbExpect(8'h04, 8'h04); sbMonitor("R10 order");
    tick(1); sbExpect(8'h04, 8'h04); sbMonitor("R10 dropped write");
    checkBit("R10", "underflow after drain", underflow, 1'b1);
    trigEnable = 1'b0;

    // R9: direct path and timer gating
    digEnable = 1'b0; directData0 = 8'hC3; directData1 = 8'h5A;
    tick(1); sbExpect(8'hC3, 8'h5A); sbMonitor("R9 direct");
    push(8'hB0);
    trigEnable = 1'b1;
    tick(5); sbExpect(8'hC3, 8'h5A); sbMonitor("R9 direct held");
    digEnable = 1'b1; trigEnable = 1'b0;
    tick(1); sbExpect(8'h04, 8'h04); sbMonitor("R9 no trigger while direct");
    trigEnable = 1'b1;
    tick(1); sbExpect(8'hB0, 8'hB0); sbMonitor("R9 controller path");
    trigEnable = 1'b0;

    tick(2);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule